// File: doc/BRIEF.md
# Parallel Non-Volatile Memory Byte Programmer

This block sits on the host side of an asynchronous parallel non-volatile memory with an 11-bit address and an 8-bit data bus. It takes one write request at a time through a valid/ready handshake and drives the memory pins: address, data out with its tri-state enable, and active-low chip select, read strobe and write strobe. It produces a write cycle in which the write strobe controls the timing. Each interval is computed in clock cycles from nanosecond parameters and the clock period.

The memory needs time to program the byte internally. During that time, a read of the same location returns the top data bit inverted. The block therefore releases its data drivers and reads that address repeatedly. It compares the returned top bit with the top bit it wrote. It ends the request with a one-cycle done pulse when the two agree. It ends with a one-cycle timeout pulse when the number of reads allowed by the worst-case programming time runs out. A new request is taken only once the previous one has ended.

Top module: `nvm_byte_prog`

## Requirements
- R1: After reset, `wr_ready` is 1, `nvm_ce_n`, `nvm_oe_n` and `nvm_we_n` are 1, and `nvm_dq_oe`, `wr_done` and `wr_timeout` are 0.
- R2: A request is taken on a rising edge where `wr_valid` and `wr_ready` are both 1. `wr_ready` is 1 only while no request is active, is 0 from the cycle after acceptance, and is 1 again in the cycle where `wr_done` or `wr_timeout` pulses. `wr_valid` is ignored while `wr_ready` is 0.
- R3: After acceptance, the write runs in three steps. First comes one setup cycle with `nvm_ce_n`=0, `nvm_we_n`=1, `nvm_oe_n`=1 and `nvm_dq_oe`=1. Next, `nvm_we_n`=0 for STROBE_CYC cycles, where STROBE_CYC is the largest of ceil(WE_LOW_NS/CLK_NS), ceil(DATA_SETUP_NS/CLK_NS) and ceil(ADDR_HOLD_NS/CLK_NS); `nvm_ce_n` stays 0 and `nvm_oe_n` stays 1. Last comes one hold cycle with `nvm_we_n`=1, `nvm_ce_n`=0 and data still driven.
- R4: `nvm_dq_oe` and a low `nvm_oe_n` never occur in the same cycle.
- R5: After the hold cycle there is one turnaround cycle with all three strobes at 1 and `nvm_dq_oe`=0. `nvm_dq_oe` then stays 0 until the next request is taken.
- R6: Each poll read holds `nvm_ce_n`=0, `nvm_oe_n`=0 and `nvm_we_n`=1 for ACCESS_CYC = ceil(ACCESS_NS/CLK_NS)+1 cycles. `nvm_dq_i[7]` is sampled at the rising edge that ends the last of these cycles.
- R7: If the sampled bit equals bit 7 of the written data, `wr_done` is 1 for exactly the next cycle and the block is idle in that cycle.
- R8: If the sampled bit differs and reads remain, there follow RECOVER_CYC cycles with all three strobes at 1 and `nvm_dq_oe`=0, then another poll read.
- R9: At most POLL_LIMIT reads are made per request, where POLL_LIMIT = max(1, ceil(WRITE_MAX_NS / ((ACCESS_CYC+RECOVER_CYC)*CLK_NS))). If read number POLL_LIMIT differs, `wr_timeout` is 1 for exactly the next cycle, the block goes idle, and no `wr_done` is given for that request.
- R10: While `nvm_ce_n` is 0, `nvm_addr` equals the address taken with the request and is stable. While `nvm_dq_oe` is 1, `nvm_dq_o` equals the data taken with the request.
- R11: `wr_done` and `wr_timeout` are never 1 in the same cycle, and neither is 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Block idle, request can be taken |
| wr_addr | input | 11 | Byte address of the request |
| wr_data | input | 8 | Byte to program |
| nvm_addr | output | 11 | Memory address bus |
| nvm_dq_o | output | 8 | Data driven toward the memory |
| nvm_dq_oe | output | 1 | Enable for the host data drivers |
| nvm_dq_i | input | 8 | Data returned by the memory |
| nvm_ce_n | output | 1 | Chip select, active low |
| nvm_oe_n | output | 1 | Read strobe, active low |
| nvm_we_n | output | 1 | Write strobe, active low |
| wr_done | output | 1 | One-cycle pulse: programming confirmed |
| wr_timeout | output | 1 | One-cycle pulse: poll limit exhausted |

## Verification
The assertions assume that reset is applied before the first request. They also assume that `nvm_dq_i` carries meaning only while both the chip select and the read strobe are low, and that `wr_addr` and `wr_data` need to be valid only on the accepting edge. The bench's memory model follows these assumptions. It drives defined data only during a read. It returns the inverted top bit for a programmable number of cycles after the write strobe rises, and true stored data after that. The request inputs change one time unit after a rising edge, and the bench holds `wr_valid` high with different contents while the block is busy.

// File: rtl/nvmw_pkg.sv
// Shared types for the byte programmer: sequencer states, the pin strobe
// bundle, the strobe pattern of each state and a ceiling-division helper.
// Assumes nothing beyond IEEE 1800-2017 packages.
package nvmw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_TURN   = 3'd4,
        ST_READ   = 3'd5,
        ST_RECOV  = 3'd6
    } nvmw_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } nvmw_strobe_t;

    // Pin pattern that belongs to each sequencer state.
    function automatic nvmw_strobe_t strobe_for(nvmw_state_e s);
        nvmw_strobe_t p;
        p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        case (s)
            ST_SETUP:  p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
            ST_STROBE: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
            ST_HOLD:   p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
            ST_READ:   p = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
            default:   p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        endcase
        return p;
    endfunction

    // Integer ceiling division for parameter arithmetic.
    function automatic int ceil_div(int num, int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/nvmw_phase_timer.sv
// Down-counter that times the length of one sequencer phase.
// A load of N-1 on entry into a phase makes that phase last N cycles;
// 'expired' is high in the phase's final cycle. Assumes the loader only
// loads on a phase change.
module nvmw_phase_timer #(
    parameter int TMR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             expired
);

    logic [TMR_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Final cycle of the current phase.
    always_comb expired = (cnt_q == '0);

endmodule

// File: rtl/nvmw_poll_counter.sv
// Counts the mismatching poll reads of one request and flags the read
// that is the last one permitted. Assumes 'clr' comes at the start of
// the first read and 'inc' at each mismatch that is not the last.
module nvmw_poll_counter #(
    parameter int LIMIT  = 4,
    parameter int POLL_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    logic [POLL_W-1:0] cnt_q;

    // Clear per request, step once per failed read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The read in progress is read number LIMIT.
    always_comb last = (cnt_q == POLL_W'(LIMIT - 1));

    // R9
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < POLL_W'(LIMIT));

endmodule

// File: rtl/nvmw_strobe_reg.sv
// Registers the memory control pins from the sequencer's next state, so
// the pins change only at a clock edge and never glitch on decode.
// Assumes the pin pattern is a pure function of the state.
module nvmw_strobe_reg (
    input  logic                 clk,
    input  logic                 rst_n,
    input  nvmw_pkg::nvmw_state_e state_d,
    output nvmw_pkg::nvmw_strobe_t pins_q
);
    import nvmw_pkg::*;

    // Pins follow the state being entered; reset parks them idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= strobe_for(ST_IDLE);
        end else begin
            pins_q <= strobe_for(state_d);
        end
    end

endmodule

// File: rtl/nvm_byte_prog.sv
// Host-side sequencer that programs one byte of a parallel non-volatile
// memory and then polls the same address until the top data bit reads
// back true, or a poll limit sized from the worst-case programming time
// is exhausted. Assumes the memory returns the inverted top bit while
// busy, and that reset is applied before use.
module nvm_byte_prog #(
    parameter int ADDR_W        = 11,
    parameter int DATA_W        = 8,
    parameter int CLK_NS        = 10,
    parameter int WE_LOW_NS     = 110,
    parameter int DATA_SETUP_NS = 60,
    parameter int ADDR_HOLD_NS  = 100,
    parameter int ACCESS_NS     = 90,
    parameter int RECOVER_CYC   = 2,
    parameter int WRITE_MAX_NS  = 10_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] nvm_addr,
    output logic [DATA_W-1:0] nvm_dq_o,
    output logic              nvm_dq_oe,
    input  logic [DATA_W-1:0] nvm_dq_i,
    output logic              nvm_ce_n,
    output logic              nvm_oe_n,
    output logic              nvm_we_n,
    output logic              wr_done,
    output logic              wr_timeout
);
    import nvmw_pkg::*;

    localparam int LOW_A      = ceil_div(WE_LOW_NS, CLK_NS);
    localparam int LOW_B      = ceil_div(DATA_SETUP_NS, CLK_NS);
    localparam int LOW_C      = ceil_div(ADDR_HOLD_NS, CLK_NS);
    localparam int LOW_AB     = (LOW_A > LOW_B) ? LOW_A : LOW_B;
    localparam int STROBE_CYC = (LOW_AB > LOW_C) ? LOW_AB : LOW_C;
    localparam int ACCESS_CYC = ceil_div(ACCESS_NS, CLK_NS) + 1;
    localparam int POLL_PER   = ACCESS_CYC + RECOVER_CYC;
    localparam int LIMIT_RAW  = ceil_div(WRITE_MAX_NS, POLL_PER * CLK_NS);
    localparam int POLL_LIMIT = (LIMIT_RAW < 1) ? 1 : LIMIT_RAW;
    localparam int TMR_MAX_A  = (STROBE_CYC > ACCESS_CYC) ? STROBE_CYC : ACCESS_CYC;
    localparam int TMR_MAX    = (TMR_MAX_A > RECOVER_CYC) ? TMR_MAX_A : RECOVER_CYC;
    localparam int TMR_W      = $clog2(TMR_MAX + 1);
    localparam int POLL_W     = $clog2(POLL_LIMIT + 1);
    localparam int MSB        = DATA_W - 1;

    nvmw_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              tmr_load, tmr_done;
    logic [TMR_W-1:0]  tmr_val;
    logic              poll_clr, poll_inc, poll_last;
    logic              take, done_d, tout_d;
    logic              done_q, tout_q;
    nvmw_strobe_t      pins_q;

    nvmw_phase_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    nvmw_poll_counter #(.LIMIT(POLL_LIMIT), .POLL_W(POLL_W)) u_polls (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (poll_clr),
        .inc   (poll_inc),
        .last  (poll_last)
    );

    nvmw_strobe_reg u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .pins_q  (pins_q)
    );

    // Next-state, phase timer loads and end-of-request decisions.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        poll_clr = 1'b0;
        poll_inc = 1'b0;
        take     = 1'b0;
        done_d   = 1'b0;
        tout_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_valid) begin
                    take     = 1'b1;
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(STROBE_CYC - 1);
                end
            end
            ST_STROBE: begin
                if (tmr_done) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    state_d  = ST_TURN;
                    tmr_load = 1'b1;
                end
            end
            ST_TURN: begin
                if (tmr_done) begin
                    state_d  = ST_READ;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(ACCESS_CYC - 1);
                    poll_clr = 1'b1;
                end
            end
            ST_READ: begin
                if (tmr_done) begin
                    if (nvm_dq_i[MSB] == data_q[MSB]) begin
                        done_d  = 1'b1;
                        state_d = ST_IDLE;
                    end else if (poll_last) begin
                        tout_d  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        poll_inc = 1'b1;
                        state_d  = ST_RECOV;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(RECOVER_CYC - 1);
                    end
                end
            end
            ST_RECOV: begin
                if (tmr_done) begin
                    state_d  = ST_READ;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(ACCESS_CYC - 1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer state and the one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            tout_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
            tout_q  <= tout_d;
        end
    end

    // Request capture; address and data stay put until the next request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (take) begin
            addr_q <= wr_addr;
            data_q <= wr_data;
        end
    end

    // Port drive.
    always_comb begin
        wr_ready   = (state_q == ST_IDLE);
        nvm_addr   = addr_q;
        nvm_dq_o   = data_q;
        nvm_dq_oe  = pins_q.drive;
        nvm_ce_n   = pins_q.ce_n;
        nvm_oe_n   = pins_q.oe_n;
        nvm_we_n   = pins_q.we_n;
        wr_done    = done_q;
        wr_timeout = tout_q;
    end

    // R4
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nvm_dq_oe |-> nvm_oe_n);

    // R3
    strobe_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nvm_we_n |-> (!nvm_ce_n && nvm_dq_oe && nvm_oe_n));

    // R6
    read_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nvm_oe_n |-> (!nvm_ce_n && nvm_we_n));

    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nvm_ce_n && $past(!nvm_ce_n)) |-> $stable(nvm_addr));

    // R11
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_done && wr_timeout));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done || wr_timeout) |=> !(wr_done || wr_timeout));

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nvm_ce_n || nvm_dq_oe) |-> !wr_ready);

endmodule

// File: tb/nvm_byte_prog_tb.sv
module nvm_byte_prog_tb;

    localparam int CLK_PERIOD = 10;
    localparam int T_NS       = 10;
    localparam int MAX_NS     = 3000;
    // Expected counts, from the requirement formulas.
    localparam int STROBE_N   = 11;   // max(ceil(110/10), ceil(60/10), ceil(100/10))
    localparam int ACCESS_N   = 10;   // ceil(90/10)+1
    localparam int RECOVER_N  = 2;
    localparam int LIMIT_N    = 25;   // ceil(3000/(12*10))

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [10:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [10:0] nvm_addr;
    logic [7:0]  nvm_dq_o;
    logic        nvm_dq_oe;
    logic [7:0]  nvm_dq_i;
    logic        nvm_ce_n, nvm_oe_n, nvm_we_n;
    logic        wr_done, wr_timeout;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_byte_prog #(.CLK_NS(T_NS), .WRITE_MAX_NS(MAX_NS), .RECOVER_CYC(RECOVER_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .nvm_addr(nvm_addr),
        .nvm_dq_o(nvm_dq_o), .nvm_dq_oe(nvm_dq_oe), .nvm_dq_i(nvm_dq_i),
        .nvm_ce_n(nvm_ce_n), .nvm_oe_n(nvm_oe_n), .nvm_we_n(nvm_we_n),
        .wr_done(wr_done), .wr_timeout(wr_timeout)
    );

    // ---------------- memory model ----------------
    logic [7:0]  cells [2048];
    logic        we_prev = 1'b1;
    int          busy_cnt = 0;
    int          busy_cfg = 0;
    logic [10:0] pend_addr = '0;
    logic [7:0]  pend_data = '0;

    initial for (int i = 0; i < 2048; i++) cells[i] = 8'h00;

    always @(posedge clk) begin
        we_prev <= nvm_we_n;
        if (!we_prev && nvm_we_n) begin
            cells[nvm_addr] <= nvm_dq_o;
            pend_addr <= nvm_addr;
            pend_data <= nvm_dq_o;
            busy_cnt  <= busy_cfg;
        end else if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
        end
    end

    assign nvm_dq_i = (nvm_ce_n || !nvm_oe_n == 1'b0) ? 8'hFF :
                      ((busy_cnt > 0 && nvm_addr == pend_addr) ? {~pend_data[7], 7'h2A}
                                                                : cells[nvm_addr]);

    // ---------------- reference model ----------------
    typedef struct packed {
        logic ce_n, oe_n, we_n, drv, rdy, dn, to, last;
        logic [2:0] kind;
    } exp_t;

    exp_t q[$];
    logic [10:0] m_addr = '0;
    logic [7:0]  m_data = '0;
    int          polls = 0;

    function automatic exp_t mk(bit ce, bit oe, bit we, bit drv, bit rdy, bit dn, bit to, bit last, int k);
        exp_t e;
        e = '{ce_n: ce, oe_n: oe, we_n: we, drv: drv, rdy: rdy, dn: dn, to: to, last: last, kind: 3'(k)};
        return e;
    endfunction

    function automatic string tag_of(logic [2:0] k);
        case (k)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R8";
            3'd5: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic push_reads();
        for (int i = 0; i < ACCESS_N; i++) q.push_back(mk(0,0,1,0,0,0,0, i == ACCESS_N-1, 3));
    endtask

    always @(negedge clk) begin
        exp_t e;
        logic [6:0] act, expv;
        if (rst_n && !finished) begin
            e = (q.size() != 0) ? q.pop_front() : mk(1,1,1,0,1,0,0,0,0);
            act  = {nvm_ce_n, nvm_oe_n, nvm_we_n, nvm_dq_oe, wr_ready, wr_done, wr_timeout};
            expv = {e.ce_n, e.oe_n, e.we_n, e.drv, e.rdy, e.dn, e.to};
            checks++;
            if (act !== expv) begin
                fails++;
                $display("FAIL %s: pins ce,oe,we,oe_dq,rdy,done,to actual %b expected %b", tag_of(e.kind), act, expv);
            end
            if (!e.ce_n) begin
                checks++;
                if (nvm_addr !== m_addr) begin
                    fails++;
                    $display("FAIL R10: address actual %h expected %h", nvm_addr, m_addr);
                end
            end
            if (e.drv) begin
                checks++;
                if (nvm_dq_o !== m_data) begin
                    fails++;
                    $display("FAIL R10: data actual %h expected %h", nvm_dq_o, m_data);
                end
            end
            checks++;
            if (nvm_dq_oe && !nvm_oe_n) begin
                fails++;
                $display("FAIL R4: contention actual oe_dq=%b oe_n=%b expected not 1/0", nvm_dq_oe, nvm_oe_n);
            end
            if (wr_done && wr_timeout) begin
                fails++;
                $display("FAIL R11: done/timeout actual 11 expected not both");
            end
            if (e.last) begin
                polls++;
                if (nvm_dq_i[7] == m_data[7]) q.push_back(mk(1,1,1,0,1,1,0,0,5));
                else if (polls == LIMIT_N) q.push_back(mk(1,1,1,0,1,0,1,0,6));
                else begin
                    for (int i = 0; i < RECOVER_N; i++) q.push_back(mk(1,1,1,0,0,0,0,0,4));
                    push_reads();
                end
            end
            if (e.rdy && wr_valid) begin
                m_addr = wr_addr;
                m_data = wr_data;
                polls  = 0;
                q.push_back(mk(0,1,1,1,0,0,0,0,1));
                for (int i = 0; i < STROBE_N; i++) q.push_back(mk(0,1,0,1,0,0,0,0,1));
                q.push_back(mk(0,1,1,1,0,0,0,0,1));
                q.push_back(mk(1,1,1,0,0,0,0,0,2));
                push_reads();
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic chk(bit ok, string msg, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", msg, act, expv);
        end
    endtask

    task automatic wait_end(output bit got_done, output bit got_to);
        do @(negedge clk); while (!(wr_done || wr_timeout));
        got_done = wr_done;
        got_to   = wr_timeout;
    endtask

    task automatic one_write(logic [10:0] a, logic [7:0] d, int busy, bit want_to);
        bit gd, gt;
        busy_cfg = busy;
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        do @(negedge clk); while (!wr_ready);
        @(posedge clk); #1;
        wr_valid = 1'b0; wr_addr = ~a; wr_data = ~d;
        wait_end(gd, gt);
        if (want_to) chk(gt && !gd, "R9 timeout outcome", {30'd0, gd, gt}, 1);
        else         chk(gd && !gt, "R7 done outcome", {30'd0, gd, gt}, 2);
    endtask

    initial begin
        bit gd, gt;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(wr_ready && nvm_ce_n && nvm_oe_n && nvm_we_n && !nvm_dq_oe && !wr_done && !wr_timeout,
            "R1 reset state", {25'd0, wr_ready, nvm_ce_n, nvm_oe_n, nvm_we_n, nvm_dq_oe, wr_done, wr_timeout}, 7'b1111000);

        one_write(11'h123, 8'h3C, 0, 0);     // R7 first read matches, bit7 = 0
        one_write(11'h7FF, 8'hA5, 40, 0);    // R8 several polls, bit7 = 1
        one_write(11'h000, 8'h00, 25, 0);    // R8 bit7 = 0 while busy
        one_write(11'h2AA, 8'h80, 1_000_000, 1); // R9 limit reached
        one_write(11'h2AA, 8'h7F, 3, 0);     // R7 after a timeout

        // R2: request held during a busy transaction waits for the idle cycle
        busy_cfg = 20;
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = 11'h055; wr_data = 8'hC3;
        do @(negedge clk); while (!wr_ready);
        @(posedge clk); #1;
        wr_addr = 11'h5AA; wr_data = 8'h18;
        wait_end(gd, gt);
        chk(wr_ready == 1'b1, "R2 ready in result cycle", wr_ready, 1);
        chk(gd, "R7 first of back-to-back", gd, 1);
        @(posedge clk); #1;
        wr_valid = 1'b0;
        @(negedge clk);
        chk(!wr_ready && !nvm_ce_n, "R2 second request taken", wr_ready, 0);
        wait_end(gd, gt);
        chk(gd, "R7 second of back-to-back", gd, 1);
        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R2 model drained", q.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule